// File: doc/BRIEF.md
# Phase-Frequency Detector with Antibacklash Overlap

This block compares two edge streams, one from a reference divider and one from a feedback divider, and produces the pump-up and pump-down requests for a charge pump. A rising edge on the reference input sets the pump-up output. A rising edge on the feedback input sets the pump-down output. Each output stays high until both are high. The time by which one output leads the other gives the size and sign of the phase error.

Once both outputs are high, the clear that drops them is held back by a counter running on a fast sampling clock. Every comparison therefore ends with both outputs high together for a fixed number of cycles. This overlap keeps the transfer function free of a dead zone near zero phase error, so in lock both outputs emit short pulses of equal width. Both divider inputs pass through a synchronizer and a rising-edge detector before they act. An edge that lands while the clear is pending is held and applied right after the clear.

Top module: `antibacklash_pfd`

## Requirements
- R1: A synchronous reset drives both outputs low on the next clock and empties the overlap counter, so the first comparison after reset has the normal overlap width.
- R2: A rising edge on `ref_edge_i` drives `up_o` high. The input is sampled through `SYNC_STAGES` flops plus an edge register, so with `SYNC_STAGES`=2 the output is high after the third rising clock edge that follows the input change.
- R3: A rising edge on `fb_edge_i` drives `dn_o` high with the same latency as R2.
- R4: The leading output stays high from its own start until both outputs have been high together for `HOLD_CYCLES`+1 cycles. Its width is therefore the edge separation in cycles plus `HOLD_CYCLES`+1.
- R5: The lagging output is high for exactly `HOLD_CYCLES`+1 cycles, and both outputs go low on the same clock edge.
- R6: When both edges come in the same cycle, both outputs rise together and stay high for `HOLD_CYCLES`+1 cycles (no dead zone).
- R7: With `HOLD_CYCLES`=0 the clear acts in the first cycle in which both outputs are high, which gives an overlap of exactly one cycle.
- R8: A rising edge that comes while both outputs are high, including the clear cycle itself, is kept. It sets its output on the clock edge that follows the one on which the outputs fell.
- R9: A further rising edge on an input whose output is already high alone has no effect: the widths stay the same and no extra pulse follows.
- R10: An input held high gives a single edge. After that comparison ends, the output stays low while the input remains high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_edge_i | input | 1 | Reference divider output (asynchronous) |
| fb_edge_i | input | 1 | Feedback divider output (asynchronous) |
| up_o | output | 1 | Pump-up request |
| dn_o | output | 1 | Pump-down request |

## Verification
Two functions can fall in the same cycle. In one case, a fresh reference edge arrives while the delayed clear is still pending. In the other, both set paths fire in the same cycle. The first case is provoked by pulsing the reference input low and high again so that its detected edge lands inside the overlap window. The scoreboard then expects the pump-up output to fall together with pump-down and to rise again exactly one cycle later. The second case is provoked by raising both inputs on the same edge. The expected result is equal start cycles and equal widths of `HOLD_CYCLES`+1, plus a single-cycle overlap on a second instance built with zero hold.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef struct packed {
        logic up;
        logic dn;
        logic pend_up;
        logic pend_dn;
    } phase_state_t;

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              last;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d.sync[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        st_d.last = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise = st_q.sync[STAGES-1] & ~st_q.last;

    // R10: a level yields one detected edge only
    a_r10_single_rise: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/pfd_clear_delay.sv
module pfd_clear_delay #(
    parameter int HOLD_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic both,
    output logic clear
);
    localparam int CW = $clog2(HOLD_CYCLES + 2);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        clear = both && (cnt_q == CW'(HOLD_CYCLES));
        if (both && !clear) begin
            cnt_d = cnt_q + 1'b1;
        end else begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R4: the counter never passes the hold length
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(HOLD_CYCLES));

    // R5: a clear always ends the overlap on the next edge
    a_r5_clear_ends_overlap: assert property (@(posedge clk) disable iff (rst)
        clear |=> !both);

endmodule

// File: rtl/pfd_phase_core.sv
module pfd_phase_core
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ref_rise,
    input  logic fb_rise,
    input  logic clear,
    output logic both,
    output logic up,
    output logic dn
);
    phase_state_t st_d, st_q;

    always_comb begin
        both         = st_q.up & st_q.dn;
        st_d.pend_up = both & (st_q.pend_up | ref_rise);
        st_d.pend_dn = both & (st_q.pend_dn | fb_rise);
        st_d.up      = clear ? 1'b0 : (st_q.up | ref_rise | st_q.pend_up);
        st_d.dn      = clear ? 1'b0 : (st_q.dn | fb_rise  | st_q.pend_dn);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign up = st_q.up;
    assign dn = st_q.dn;

    // R5: outputs never fall apart from each other outside reset
    a_r5_joint_fall: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(st_q.up)) |-> $fell(st_q.dn));

    // R8: a held edge sets its output right after the clear
    a_r8_pending_up: assert property (@(posedge clk) disable iff (rst)
        (st_q.pend_up && !both) |=> st_q.up);

    a_r8_pending_dn: assert property (@(posedge clk) disable iff (rst)
        (st_q.pend_dn && !both) |=> st_q.dn);

    // R2: pump-up only rises from an edge or a held edge
    a_r2_up_cause: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(st_q.up)) |-> ($past(ref_rise) || $past(st_q.pend_up)));

endmodule

// File: rtl/antibacklash_pfd.sv
module antibacklash_pfd #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_edge_i,
    input  logic fb_edge_i,
    output logic up_o,
    output logic dn_o
);
    logic ref_rise, fb_rise, both, clear;

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk(clk), .rst(rst), .din(ref_edge_i), .rise(ref_rise)
    );

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_fb_sync (
        .clk(clk), .rst(rst), .din(fb_edge_i), .rise(fb_rise)
    );

    pfd_phase_core u_core (
        .clk(clk), .rst(rst), .ref_rise(ref_rise), .fb_rise(fb_rise),
        .clear(clear), .both(both), .up(up_o), .dn(dn_o)
    );

    pfd_clear_delay #(.HOLD_CYCLES(HOLD_CYCLES)) u_delay (
        .clk(clk), .rst(rst), .both(both), .clear(clear)
    );

    // R1: reset leaves both outputs low
    a_r1_reset_low: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!up_o && !dn_o));

endmodule

// File: tb/tb_antibacklash_pfd.sv
module tb_antibacklash_pfd;
    localparam int SYNC = 2;
    localparam int HOLD = 3;
    localparam int LAT  = SYNC + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic up, dn, up0, dn0;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit abort = 1'b0;
    bit done = 1'b0;

    typedef struct {
        int    us;
        int    ds;
        int    fin;
        string tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    antibacklash_pfd #(.SYNC_STAGES(SYNC), .HOLD_CYCLES(HOLD)) dut (
        .clk(clk), .rst(rst), .ref_edge_i(ref_in), .fb_edge_i(fb_in),
        .up_o(up), .dn_o(dn)
    );

    antibacklash_pfd #(.SYNC_STAGES(SYNC), .HOLD_CYCLES(0)) dut0 (
        .clk(clk), .rst(rst), .ref_edge_i(ref_in), .fb_edge_i(fb_in),
        .up_o(up0), .dn_o(dn0)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    // monitor: record pulse starts, compare on fall
    int us_m = -1, ds_m = -1;
    bit up_p = 0, dn_p = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (up && !up_p) us_m = cyc;
            if (dn && !dn_p) ds_m = cyc;
            if ((up_p && !up) || (dn_p && !dn)) begin
                if (abort) begin
                    abort = 1'b0;
                end else begin
                    chk(!up && !dn, "R5 joint fall", {30'd0, up, dn}, 0);
                    if (q.size() == 0) begin
                        chk(1'b0, "R9 unexpected pulse", cyc, -1);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        chk(us_m == e.us, {e.tag, " up start"}, us_m, e.us);
                        chk(ds_m == e.ds, {e.tag, " dn start"}, ds_m, e.ds);
                        chk(cyc == e.fin, {e.tag, " end cycle"}, cyc, e.fin);
                    end
                end
            end
        end
        up_p = up;
        dn_p = dn;
    end

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // drive one comparison; offsets in cycles from now, each input high 2 cycles
    task automatic compare_pair(input int roff, input int foff, input string tag);
        int base, span;
        exp_t e;
        base = cyc;
        e.us = base + roff + LAT;
        e.ds = base + foff + LAT;
        e.fin = imax(e.us, e.ds) + HOLD + 1;
        e.tag = tag;
        q.push_back(e);
        span = imax(roff, foff) + 2;
        for (int k = 0; k <= span; k++) begin
            ref_in = (k >= roff) && (k < roff + 2);
            fb_in  = (k >= foff) && (k < foff + 2);
            @(negedge clk);
        end
        repeat (HOLD + 8) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!up && !dn, "R1 reset state", {30'd0, up, dn}, 0);
        rst = 1'b0;
        @(negedge clk);

        // R6 equal phase, also R7 on zero-hold instance
        begin
            int c;
            exp_t e;
            c = cyc;
            e.us = c + LAT; e.ds = c + LAT; e.fin = c + LAT + HOLD + 1; e.tag = "R6 equal";
            q.push_back(e);
            ref_in = 1; fb_in = 1;
            while (cyc < c + LAT) @(negedge clk);
            chk(up0 && dn0, "R7 zero hold overlap high", {30'd0, up0, dn0}, 3);
            @(negedge clk);
            chk(!up0 && !dn0, "R7 zero hold one cycle", {30'd0, up0, dn0}, 0);
            ref_in = 0; fb_in = 0;
            repeat (HOLD + 6) @(negedge clk);
        end

        compare_pair(0, 4, "R4 ref leads");   // R2, R4, R5
        compare_pair(5, 0, "R3 fb leads");    // R3, R4, R5
        compare_pair(0, 1, "R5 lag by one");

        // R9: extra ref edge while up alone is high
        begin
            int c;
            exp_t e;
            c = cyc;
            e.us = c + LAT; e.ds = c + 10 + LAT; e.fin = c + 10 + LAT + HOLD + 1; e.tag = "R9 extra edge";
            q.push_back(e);
            for (int k = 0; k <= 12; k++) begin
                ref_in = (k < 2) || (k >= 5 && k < 7);
                fb_in  = (k >= 10) && (k < 12);
                @(negedge clk);
            end
            repeat (HOLD + 8) @(negedge clk);
            chk(!up && !dn, "R9 no extra pulse", {30'd0, up, dn}, 0);
        end

        // R8: second ref edge lands inside the overlap window
        begin
            int c, fin1;
            exp_t e;
            c = cyc;
            fin1 = c + LAT + HOLD + 1;
            e.us = c + LAT; e.ds = c + LAT; e.fin = fin1; e.tag = "R8 first";
            q.push_back(e);
            e.us = fin1 + 1; e.ds = c + 12 + LAT; e.fin = c + 12 + LAT + HOLD + 1; e.tag = "R8 held edge";
            q.push_back(e);
            for (int k = 0; k <= 14; k++) begin
                ref_in = (k == 0) || (k >= 2 && k < 4);
                fb_in  = (k < 2) || (k >= 12 && k < 14);
                @(negedge clk);
            end
            repeat (HOLD + 8) @(negedge clk);
        end

        // R10: ref held high across and after a comparison
        begin
            int c;
            exp_t e;
            c = cyc;
            e.us = c + LAT; e.ds = c + 2 + LAT; e.fin = c + 2 + LAT + HOLD + 1; e.tag = "R10 held level";
            q.push_back(e);
            ref_in = 1;
            @(negedge clk); @(negedge clk);
            fb_in = 1;
            @(negedge clk); @(negedge clk);
            fb_in = 0;
            repeat (HOLD + 10) @(negedge clk);
            chk(!up, "R10 stays low", up, 0);
            ref_in = 0;
            repeat (4) @(negedge clk);
        end

        // R1: reset during overlap, then a clean comparison
        begin
            int c;
            c = cyc;
            ref_in = 1; fb_in = 1;
            while (cyc < c + LAT + 1) @(negedge clk);
            abort = 1'b1;
            rst = 1'b1; ref_in = 0; fb_in = 0;
            @(negedge clk);
            chk(!up && !dn, "R1 reset clears outputs", {30'd0, up, dn}, 0);
            rst = 1'b0;
            abort = 1'b0;
            up_p = 0; dn_p = 0;
            repeat (3) @(negedge clk);
        end
        compare_pair(0, 0, "R1 after reset");

        repeat (5) @(negedge clk);
        chk(q.size() == 0, "R5 all pulses seen", q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule